// File: doc/BRIEF.md
# Burst Write Engine for a 512-bit Memory Port

This engine moves a run of 512-bit words from a valid/ready input stream into memory through the write half of an AXI4 manager port. A single `start` pulse supplies the first byte address and the number of words to write. The engine then cuts the run into incrementing bursts, issues one address request per burst, forwards the matching stream words as write beats, and gathers the write responses. It raises `done` for one cycle once every word has been written and every response has come back.

Two issue policies can be chosen at each start. In the pipelined policy, the next burst's address goes out as soon as the previous burst's data has been sent, while earlier responses are still pending. In the sequential policy, each new address waits until every earlier burst has been answered. In both policies a run-time cap limits how many bursts may be waiting for a response. A response other than OKAY sets a sticky error flag and still counts toward completion.

The input stream has no buffer. A word is taken only in a cycle where both `s_valid` and `s_ready` are high. `s_ready` follows the memory's `wready`, and it is high only while a burst's data phase is open, so memory back-pressure reaches the source in the same cycle. The source must keep `s_valid` and `s_data` steady until the word is taken. `start_addr` must be 64-byte aligned.

Top module: `axi_burst_writer`

## Requirements
- R1: A start with `total_words` = 0 pulses `done` in the cycle after the start edge. No address request is issued.
- R2: Each burst length is the smallest of 16 beats, the words still unassigned, and the beats left before the next 4 KB page. `awlen` is the burst length minus one, `awsize` = 3'b110, and `awburst` = 2'b01 (INCR). The next burst's address is the previous one plus 64 bytes per beat. A pending address request keeps `awaddr` and `awlen` steady until it is accepted.
- R3: No burst crosses a 4096-byte boundary. The page-offset word index (`awaddr[11:6]`) plus `awlen` stays below 64.
- R4: Write beats of a burst appear only after that burst's address request has been accepted. `wstrb` is all ones. `wlast` is high on exactly the final beat of each burst.
- R5: The number of bursts waiting for a response never reaches past the cap. An `outs_limit` of 0 selects 16, values from 1 to 32 are used as given, and values above 32 are treated as 32. With a long response delay, the waiting count rises to exactly the cap.
- R6: With `seq_mode` = 1, an address request is presented only while no burst is waiting for a response.
- R7: With `seq_mode` = 0, the next address request is presented in the cycle after the previous burst's last beat is accepted, provided the waiting count is below the cap.
- R8: `done` is a single-cycle pulse. It rises only when all words are written and no response is pending. `busy` is high from the cycle after a start until `done`, and after reset all outputs are idle.
- R9: A response with `bresp` other than 2'b00 sets `err`. `err` stays set after `done` until the next start clears it.
- R10: Every accepted stream word appears unchanged on `wdata`, in order. A handshake happens on the stream exactly when it happens on the W channel.
- R11: When an address request is accepted in the same cycle as a response arrives, the waiting count is unchanged. The cap and the issue policy then act on the correct count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | 32 | First byte address, 64-byte aligned |
| total_words | input | 16 | Number of 512-bit words in the run |
| seq_mode | input | 1 | 1 = sequential policy, 0 = pipelined |
| outs_limit | input | 6 | Cap on bursts awaiting response (0 = 16) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error from a non-OKAY response |
| s_data | input | 512 | Stream data word |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Stream word taken when high with s_valid |
| awaddr | output | 32 | Burst start address |
| awlen | output | 8 | Beats in burst minus one |
| awsize | output | 3 | Beat size code (64 bytes) |
| awburst | output | 2 | Burst type (INCR) |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Address request accepted |
| wdata | output | 512 | Write beat data |
| wstrb | output | 64 | Byte enables |
| wlast | output | 1 | Final beat of burst |
| wvalid | output | 1 | Write beat valid |
| wready | input | 1 | Write beat accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Response accepted |

## Verification
An address acceptance and a write response can land in the same cycle, so the waiting count has to add one and take away one at once. The bench forces this by answering each burst one cycle after its last beat, in pipelined mode with a cap of two. The next address request then meets the previous burst's response on the same edge. The check is that the next request still appears in the following cycle, as the bench's own count predicts, and that no issued request ever finds that count already at the cap.

// File: rtl/axi_burst_writer_pkg.sv
package axi_burst_writer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_DRAIN = 2'd3
  } wr_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/wr_burst_sizer.sv
module wr_burst_sizer #(
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 16,
  parameter int SLOT_W    = 6,
  parameter int BEAT_W    = 5
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [LEN_W-1:0]  remaining,
  output logic [BEAT_W-1:0] beats
);
  localparam int PAGE_BEATS = 1 << SLOT_W;

  logic [LEN_W-1:0] to_edge;
  logic [LEN_W-1:0] cap_a;
  logic [LEN_W-1:0] pick;

  always_comb begin
    to_edge = LEN_W'(PAGE_BEATS) - LEN_W'(slot);
    cap_a   = (remaining < LEN_W'(MAX_BEATS)) ? remaining : LEN_W'(MAX_BEATS);
    pick    = (to_edge < cap_a) ? to_edge : cap_a;
    beats   = BEAT_W'(pick);
  end
endmodule

// File: rtl/wr_outs_tracker.sv
module wr_outs_tracker #(
  parameter int OUTS_MAX = 32,
  parameter int OUTS_DEF = 16,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  input  logic [CNT_W-1:0] limit_cfg,
  input  logic             seq_mode,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap,
  output logic             can_issue,
  output logic             idle
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (limit_cfg == '0)
      cap = CNT_W'(OUTS_DEF);
    else if (limit_cfg > CNT_W'(OUTS_MAX))
      cap = CNT_W'(OUTS_MAX);
    else
      cap = limit_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({issue, retire})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count     = cnt_q;
  assign idle      = (cnt_q == '0);
  assign can_issue = (cnt_q < cap) && (!seq_mode || idle);
endmodule

// File: rtl/axi_burst_writer.sv
module axi_burst_writer
  import axi_burst_writer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 512,
  parameter int LEN_W      = 16,
  parameter int MAX_BEATS  = 16,
  parameter int OUTS_MAX   = 32,
  parameter int OUTS_DEF   = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int STRB_W    = DATA_W / 8,
  localparam int LIM_W     = $clog2(OUTS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_words,
  input  logic              seq_mode,
  input  logic [LIM_W-1:0]  outs_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready
);
  localparam int OFF_W  = $clog2(STRB_W);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int SLOT_W = PAGE_W - OFF_W;
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              seq_q;
  logic [LIM_W-1:0]  lim_q;
  logic [BEAT_W-1:0] blen_q;
  logic [BEAT_W-1:0] beat_q;
  logic              err_q;
  logic              done_q;

  logic [BEAT_W-1:0] sz_beats;
  logic [LIM_W-1:0]  outs_cnt;
  logic [LIM_W-1:0]  outs_cap;
  logic              outs_ok;
  logic              outs_idle;
  logic              aw_fire;
  logic              w_fire;
  logic              b_fire;

  wr_burst_sizer #(
    .LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS), .SLOT_W(SLOT_W), .BEAT_W(BEAT_W)
  ) sizer_i (
    .slot     (addr_q[PAGE_W-1:OFF_W]),
    .remaining(rem_q),
    .beats    (sz_beats)
  );

  wr_outs_tracker #(
    .OUTS_MAX(OUTS_MAX), .OUTS_DEF(OUTS_DEF), .CNT_W(LIM_W)
  ) outs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (aw_fire),
    .retire   (b_fire),
    .limit_cfg(lim_q),
    .seq_mode (seq_q),
    .count    (outs_cnt),
    .cap      (outs_cap),
    .can_issue(outs_ok),
    .idle     (outs_idle)
  );

  // Address channel
  assign awvalid = (state_q == ST_ADDR) && outs_ok;
  assign awaddr  = addr_q;
  assign awlen   = 8'(sz_beats - BEAT_W'(1));
  assign awsize  = 3'(OFF_W);
  assign awburst = BURST_INCR;
  assign aw_fire = awvalid && awready;

  // Data channel: direct pass-through of the stream during a data phase
  assign wvalid  = (state_q == ST_DATA) && s_valid;
  assign s_ready = (state_q == ST_DATA) && wready;
  assign wdata   = s_data;
  assign wstrb   = '1;
  assign wlast   = (state_q == ST_DATA) && (beat_q == blen_q - BEAT_W'(1));
  assign w_fire  = wvalid && wready;

  // Response channel
  assign bready  = 1'b1;
  assign b_fire  = bvalid && bready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      seq_q   <= 1'b0;
      lim_q   <= '0;
      blen_q  <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q <= start_addr;
            rem_q  <= total_words;
            seq_q  <= seq_mode;
            lim_q  <= outs_limit;
            err_q  <= 1'b0;
            if (total_words == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (aw_fire) begin
            blen_q  <= sz_beats;
            beat_q  <= '0;
            addr_q  <= addr_q + (ADDR_W'(sz_beats) << OFF_W);
            rem_q   <= rem_q - LEN_W'(sz_beats);
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (w_fire) begin
            beat_q <= beat_q + BEAT_W'(1);
            if (wlast) begin
              state_q <= (rem_q == '0) ? ST_DRAIN : ST_ADDR;
            end
          end
        end
        ST_DRAIN: begin
          if (outs_idle) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (b_fire && (bresp != RESP_OKAY)) begin
        err_q <= 1'b1;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/axi_burst_writer_chk.sv
module axi_burst_writer_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 512,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic [2:0]        awsize,
  input logic [1:0]        awburst,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W/8-1:0] wstrb,
  input logic              wvalid,
  input logic              done,
  input logic              seq_q,
  input logic [CNT_W-1:0]  outs_cnt,
  input logic [CNT_W-1:0]  outs_cap
);
  localparam int OFF_W      = $clog2(DATA_W / 8);
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_BEATS = PAGE_BYTES / (DATA_W / 8);

  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awlen <= 8'(MAX_BEATS - 1)));

  p_attr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awsize == 3'(OFF_W)) && (awburst == 2'b01));

  p_aw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid && $stable(awaddr) && $stable(awlen));

  p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> ((16'(awaddr[PAGE_W-1:OFF_W]) + 16'(awlen)) < 16'(PAGE_BEATS)));

  p_strb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (&wstrb));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outs_cnt <= outs_cap);

  p_seq_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && seq_q) |-> (outs_cnt == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (outs_cnt == '0) && !awvalid && !wvalid);
endmodule

bind axi_burst_writer axi_burst_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS),
  .PAGE_BYTES(PAGE_BYTES), .CNT_W(LIM_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
  .awburst(awburst), .awvalid(awvalid), .awready(awready), .wstrb(wstrb),
  .wvalid(wvalid), .done(done), .seq_q(seq_q), .outs_cnt(outs_cnt),
  .outs_cap(outs_cap)
);

// File: tb/axi_burst_writer_tb_top.sv
module axi_burst_writer_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 512;
  localparam int LEN_W  = 16;
  localparam int LIM_W  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  total_words;
  logic              seq_mode;
  logic [LIM_W-1:0]  outs_limit;
  logic              busy, done, err;
  logic [DATA_W-1:0] s_data;
  logic              s_valid, s_ready;
  logic [ADDR_W-1:0] awaddr;
  logic [7:0]        awlen;
  logic [2:0]        awsize;
  logic [1:0]        awburst;
  logic              awvalid, awready;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W/8-1:0] wstrb;
  logic              wlast, wvalid, wready;
  logic [1:0]        bresp;
  logic              bvalid, bready;

  axi_burst_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .total_words(total_words), .seq_mode(seq_mode), .outs_limit(outs_limit),
    .busy(busy), .done(done), .err(err), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awburst(awburst), .awvalid(awvalid), .awready(awready), .wdata(wdata),
    .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready)
  );

  typedef struct {
    logic [31:0] addr;
    int          len;
  } aw_exp_t;

  aw_exp_t     aw_q[$];
  int          b_due[$];
  logic [1:0]  b_code[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int run_id = 0;
  int b_lat = 1, err_burst = -1, cur_limit = 16;
  bit cur_seq = 1'b0, thr = 1'b0;
  int bench_outs = 0, max_outs = 0, cur_len = 0, w_beat = 0, w_open = 0;
  int w_idx = 0, src_idx = 0, src_total = 0, b_sent = 0;
  int aw_cnt = 0, done_cnt = 0, coin_cnt = 0;
  bit expect_aw = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [DATA_W-1:0] pattern(int idx);
    logic [31:0] w;
    w = (32'(idx) + 32'(run_id) * 32'd8192) * 32'h9E3779B1 ^ 32'h00C0FFEE;
    return {(DATA_W/32){w}};
  endfunction

  task automatic chk(input bit ok, input string req, input string msg,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, exp);
    end
  endtask

  // Memory-side responder, stream source and scoreboard monitor
  initial begin
    awready = 1'b0; wready = 1'b0; bvalid = 1'b0; bresp = 2'b00;
    s_valid = 1'b0; s_data = '0;
    forever begin
      bit pend, aw_f, b_f;
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      awready = thr ? lfsr[0] : 1'b1;
      wready  = thr ? lfsr[3] : 1'b1;
      s_valid = (src_idx < src_total) && (thr ? lfsr[7] : 1'b1);
      s_data  = pattern(src_idx);
      bvalid  = (b_due.size() > 0) && (b_due[0] <= cyc);
      bresp   = bvalid ? b_code[0] : 2'b00;
      #1;
      if (!rst_n) continue;
      pend = 1'b0;
      if (expect_aw) begin
        chk(awvalid === 1'b1, "R7", "next AW not presented after WLAST", awvalid, 1);
        expect_aw = 1'b0;
      end
      aw_f = awvalid && awready;
      b_f  = bvalid && bready;
      if (aw_f) begin
        aw_cnt++;
        if (aw_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected AW", aw_cnt, 0);
        end else begin
          aw_exp_t e;
          e = aw_q.pop_front();
          chk(awaddr === e.addr, "R3", "awaddr", awaddr, e.addr);
          chk(awlen === 8'(e.len - 1), "R2", "awlen", awlen, e.len - 1);
          chk(awsize === 3'd6 && awburst === 2'b01, "R2", "awsize/awburst",
              {awsize, awburst}, {3'd6, 2'b01});
          chk(bench_outs < cur_limit, "R5", "AW issued at cap", bench_outs, cur_limit);
          if (cur_seq) chk(bench_outs == 0, "R6", "AW with pending responses", bench_outs, 0);
          cur_len = e.len; w_beat = 0; w_open = 1;
        end
      end
      if (wvalid && wready) begin
        chk(w_open == 1, "R4", "W beat before its AW", w_open, 1);
        chk(wdata === pattern(w_idx), "R10", "wdata word mismatch", w_idx, w_idx);
        chk(&wstrb, "R4", "wstrb not all ones", 0, 1);
        chk(wlast === (w_beat == cur_len - 1), "R4", "wlast position", wlast,
            (w_beat == cur_len - 1));
        chk(s_ready === 1'b1 && s_valid === 1'b1, "R10", "stream handshake mismatch",
            s_ready, 1);
        w_beat++; w_idx++;
        if (w_beat == cur_len) begin
          w_open = 0;
          b_due.push_back(cyc + b_lat);
          b_code.push_back((b_sent == err_burst) ? 2'b10 : 2'b00);
          b_sent++;
          if (!cur_seq && aw_q.size() > 0) pend = 1'b1;
        end
      end
      if (s_valid && s_ready) src_idx++;
      if (b_f) begin
        void'(b_due.pop_front());
        void'(b_code.pop_front());
      end
      if (aw_f && b_f) coin_cnt++;
      bench_outs = bench_outs + (aw_f ? 1 : 0) - (b_f ? 1 : 0);
      if (bench_outs > max_outs) max_outs = bench_outs;
      if (pend) expect_aw = (bench_outs < cur_limit);
      if (done === 1'b1) begin
        done_cnt++;
        chk(aw_q.size() == 0 && bench_outs == 0 && w_idx == src_total, "R8",
            "done before completion", bench_outs, 0);
      end
    end
  end

  task automatic run_xfer(input logic [31:0] a, input int words, input bit seq,
                          input int lim_cfg, input int lat, input int err_idx,
                          input bit throttle, output int max_seen);
    logic [31:0] ad;
    int rem, n, slot, nb, eff, wait_n;
    eff = (lim_cfg == 0) ? 16 : ((lim_cfg > 32) ? 32 : lim_cfg);
    ad = a; rem = words;
    while (rem > 0) begin
      aw_exp_t e;
      slot = int'(ad[11:6]);
      n = (rem < 16) ? rem : 16;
      if (64 - slot < n) n = 64 - slot;
      e.addr = ad; e.len = n;
      aw_q.push_back(e);
      ad = ad + 32'(n * 64);
      rem = rem - n;
    end
    nb = aw_q.size();
    cur_seq = seq; cur_limit = eff; b_lat = lat; err_burst = err_idx; thr = throttle;
    run_id++;
    w_idx = 0; src_idx = 0; src_total = words; b_sent = 0;
    max_outs = 0; aw_cnt = 0; done_cnt = 0; coin_cnt = 0;
    @(negedge clk);
    start = 1'b1; start_addr = a; total_words = 16'(words);
    seq_mode = seq; outs_limit = 6'(lim_cfg);
    @(negedge clk);
    start = 1'b0;
    #2;
    if (words == 0) chk(done === 1'b1, "R1", "zero length done timing", done, 1);
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 60000) begin
      @(negedge clk); #2; wait_n++;
    end
    chk(done_cnt == 1, "R8", "done pulse seen", done_cnt, 1);
    chk(aw_cnt == nb, "R2", "burst count", aw_cnt, nb);
    chk(w_idx == words, "R10", "words written", w_idx, words);
    chk(err === (err_idx >= 0), "R9", "error flag at done", err, (err_idx >= 0));
    repeat (3) @(negedge clk);
    #2;
    chk(done_cnt == 1, "R8", "done lasted more than one cycle", done_cnt, 1);
    chk(busy === 1'b0, "R8", "busy after done", busy, 0);
    chk(err === (err_idx >= 0), "R9", "error flag held", err, (err_idx >= 0));
    max_seen = max_outs;
  endtask

  initial begin
    int mx;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; total_words = '0;
    seq_mode = 1'b0; outs_limit = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(awvalid === 1'b0 && wvalid === 1'b0 && s_ready === 1'b0, "R8",
        "channels idle in reset", {awvalid, wvalid, s_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(done === 1'b0 && busy === 1'b0 && err === 1'b0, "R8", "status after reset",
        {done, busy, err}, 0);

    // R1: zero length
    run_xfer(32'h0000_1000, 0, 1'b0, 0, 1, -1, 1'b0, mx);
    chk(aw_cnt == 0, "R1", "AW issued for zero length", aw_cnt, 0);

    // R11 / R7: response lands with next AW, cap of two
    run_xfer(32'h0000_1000, 40, 1'b0, 2, 1, -1, 1'b0, mx);
    chk(coin_cnt > 0, "R11", "no coincident AW and B provoked", coin_cnt, 1);
    chk(mx <= 2, "R11", "waiting count beyond cap", mx, 2);

    // R3 / R6: page crossing in sequential mode with throttling
    run_xfer(32'h0000_0F80, 20, 1'b1, 0, 5, -1, 1'b1, mx);
    chk(mx == 1, "R6", "sequential peak waiting count", mx, 1);

    // R5: explicit cap of two, slow responses
    run_xfer(32'h0000_2000, 100, 1'b0, 2, 40, -1, 1'b0, mx);
    chk(mx == 2, "R5", "peak with cap 2", mx, 2);

    // R5: zero selects 16
    run_xfer(32'h0001_0000, 320, 1'b0, 0, 400, -1, 1'b0, mx);
    chk(mx == 16, "R5", "peak with default cap", mx, 16);

    // R5: values above 32 clamp to 32
    run_xfer(32'h0002_0000, 576, 1'b0, 50, 800, -1, 1'b0, mx);
    chk(mx == 32, "R5", "peak with clamped cap", mx, 32);

    // R9: error response, throttled pipelined run
    run_xfer(32'h0000_3000, 48, 1'b0, 8, 3, 1, 1'b1, mx);

    // R9: next start clears the flag; R3 short bursts at page end
    run_xfer(32'h0000_3FC0, 5, 1'b1, 4, 2, -1, 1'b0, mx);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule